// File: doc/BRIEF.md
# Stream Sideband Escape Decoder

This block sits at the far end of a narrow data pipe that carries only a data field. Upstream, the packet-end flag and the byte enables were folded into the stream as in-band marker words, so the pipe needs no sideband lanes. The decoder rebuilds a full AXI4-Stream output with TDATA, TKEEP and TLAST. The escape words are removed from the stream. The sideband values that an escape word carries are attached to the payload word that follows it.

A marker word has the fixed pattern 0xDEADBEEF in its upper 32 bits. Its low bits hold the packet-end flag and the byte-enable field. The word right after a marker is always treated as payload, even when it begins with the marker pattern too. This lets literal data that happens to start with the pattern pass through. A two-state sequencer keeps track of whether the next accepted word is such a guaranteed payload. It drives valid/ready on both sides without adding any data storage; only the decoded sideband fields are registered.

The widths are parameters. If DATA_W is too small to hold the 32-bit pattern, the byte-enable field and the end flag (that is, smaller than 32 + KEEP_W + 1), the design refuses to elaborate. Reset is asynchronous and active-low. It is expected to be released in step with the clock.

Top module: `stream_sideband_decoder`

## Requirements
- R1: When no payload is pending (idle), an input word whose bits [DATA_W-1:DATA_W-32] equal 0xDEADBEEF is a marker. It is accepted with s_tready high whatever m_tready is, and it produces no output beat (m_tvalid stays low for it).
- R2: In a marker, bit 0 is the packet-end flag and bits [KEEP_W:1] are the byte-enable field. The payload beat that follows comes out with m_tlast equal to bit 0 and, when that bit is 1, m_tkeep equal to bits [KEEP_W:1]. For example, 0xDEADBEEF00000005 followed by 0x1234567887654321 gives one beat 0x1234567887654321 with m_tlast=1 and m_tkeep=0x02.
- R3: The word accepted right after a marker is always forwarded unchanged as a payload beat, even if its upper 32 bits are 0xDEADBEEF.
- R4: A non-marker word accepted while idle is forwarded unchanged with m_tlast=0 and m_tkeep=0. For such a word, s_tready follows m_tready.
- R5: A marker with both fields zero followed by a word that begins with 0xDEADBEEF gives that word at the output with m_tlast=0 and m_tkeep=0.
- R6: m_tkeep is all zero on every beat where m_tlast is 0, even if the marker's byte-enable field was nonzero.
- R7: While a payload is pending, m_tvalid follows s_tvalid and s_tready follows m_tready. The pending state and its fields last through any number of cycles without input valid, and no beat is created during those cycles. The block returns to idle only after an output handshake.
- R8: Reset returns the block to idle and drops any pending sideband. After reset, m_tvalid is low with no input. A marker-pattern word is then treated as a marker, and a plain word comes out with both sideband signals low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Incoming word, either a marker or payload |
| s_tvalid | input | 1 | Incoming word valid |
| s_tready | output | 1 | Block accepts the incoming word |
| m_tdata | output | DATA_W | Output payload data |
| m_tkeep | output | KEEP_W | Output byte enables, nonzero only with m_tlast |
| m_tlast | output | 1 | Output packet end |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |

## Verification
Some properties hold on every cycle, and the assertions check those. A marker seen while idle is absorbed without raising the output valid. The byte enables are masked whenever the end flag is low. An idle beat carries no sideband. Output data always equals input data. A pending payload is never absorbed, and the pending state and its fields are kept until a handshake. Other behaviour can only be shown by the bench's scenarios. These cover the pairing of each marker's fields with the right following payload under random stalls on both sides, literal words that start with the pattern, the worked 64-bit example, the widest byte-enable field, and a reset that arrives while a payload is pending.

// File: rtl/sbdec_pkg.sv
`timescale 1ns/1ps
package sbdec_pkg;
  localparam int          MARK_W   = 32;
  localparam logic [31:0] MARK_PAT = 32'hDEADBEEF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } sbdec_state_e;
endpackage

// File: rtl/sbdec_marker_detect.sv
`timescale 1ns/1ps
module sbdec_marker_detect
  import sbdec_pkg::*;
#(
  parameter int KEEP_W = 8
) (
  input  logic [MARK_W-1:0] mark_bits,
  input  logic [KEEP_W:0]   field_bits,
  output logic              is_mark,
  output logic              fld_last,
  output logic [KEEP_W-1:0] fld_keep
);
  // Upper word compare against the fixed escape pattern.
  assign is_mark  = (mark_bits == MARK_PAT);
  // Field unpack: bit 0 end flag, next KEEP_W bits byte enables.
  assign fld_last = field_bits[0];
  assign fld_keep = field_bits[KEEP_W:1];
endmodule

// File: rtl/sbdec_seq.sv
`timescale 1ns/1ps
module sbdec_seq
  import sbdec_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  input  logic         is_mark,
  input  logic         m_ready,
  output logic         s_ready,
  output logic         m_valid,
  output logic         load_fields,
  output sbdec_state_e state
);
  sbdec_state_e state_nxt;
  logic         state_en;

  // Next-state and flow-control logic.
  always_comb begin
    state_nxt   = state;
    load_fields = 1'b0;
    m_valid     = s_valid;
    s_ready     = m_ready;
    case (state)
      ST_IDLE: begin
        if (is_mark) begin
          m_valid = 1'b0;
          s_ready = 1'b1;
          if (s_valid) begin
            load_fields = 1'b1;
            state_nxt   = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (s_valid && m_ready) begin
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign state_en = (state_nxt != state);

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (state_en) begin
      state <= state_nxt;
    end
  end

  AST_MARK_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && s_valid && is_mark) |-> (s_ready && !m_valid)); // R1

  AST_MARK_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && s_valid && is_mark) |=> (state == ST_DATA)); // R1

  AST_PAYLOAD_NOT_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && s_valid) |-> m_valid); // R3

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !(m_valid && m_ready)) |=> (state == ST_DATA)); // R7
endmodule

// File: rtl/sbdec_side_reg.sv
`timescale 1ns/1ps
module sbdec_side_reg #(
  parameter int KEEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              last_in,
  input  logic [KEEP_W-1:0] keep_in,
  output logic              last_q,
  output logic [KEEP_W-1:0] keep_q
);
  logic              last_d;
  logic [KEEP_W-1:0] keep_d;

  // Keep bits matter only with the end flag; drop them otherwise.
  always_comb begin
    last_d = last_in;
    keep_d = last_in ? keep_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      keep_q <= '0;
    end else if (load) begin
      last_q <= last_d;
      keep_q <= keep_d;
    end
  end

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(last_q) && $stable(keep_q))); // R7
endmodule

// File: rtl/stream_sideband_decoder.sv
`timescale 1ns/1ps
module stream_sideband_decoder
  import sbdec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  localparam int MIN_W = MARK_W + KEEP_W + 1;

  if (DATA_W < MIN_W) begin : g_width_check
    $error("stream_sideband_decoder: DATA_W too small for marker, keep and last");
  end

  logic              is_mark;
  logic              fld_last;
  logic [KEEP_W-1:0] fld_keep;
  logic              load_fields;
  logic              last_q;
  logic [KEEP_W-1:0] keep_q;
  sbdec_state_e      state;
  logic              pend;

  sbdec_marker_detect #(.KEEP_W(KEEP_W)) u_detect (
    .mark_bits  (s_tdata[DATA_W-1 -: MARK_W]),
    .field_bits (s_tdata[KEEP_W:0]),
    .is_mark    (is_mark),
    .fld_last   (fld_last),
    .fld_keep   (fld_keep)
  );

  sbdec_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_tvalid),
    .is_mark     (is_mark),
    .m_ready     (m_tready),
    .s_ready     (s_tready),
    .m_valid     (m_tvalid),
    .load_fields (load_fields),
    .state       (state)
  );

  sbdec_side_reg #(.KEEP_W(KEEP_W)) u_side (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_fields),
    .last_in (fld_last),
    .keep_in (fld_keep),
    .last_q  (last_q),
    .keep_q  (keep_q)
  );

  // Output assembly: data passes straight; sideband only while pending.
  assign pend = (state == ST_DATA);

  always_comb begin
    m_tdata = s_tdata;
    m_tlast = pend & last_q;
    m_tkeep = (pend & last_q) ? keep_q : '0;
  end

  AST_KEEP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tlast |-> (m_tkeep == '0)); // R6

  AST_IDLE_NO_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && m_tvalid) |-> (!m_tlast && m_tkeep == '0)); // R4

  AST_DATA_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata == s_tdata)); // R3
endmodule

// File: tb/stream_sideband_decoder_tb.sv
`timescale 1ns/1ps
module stream_sideband_decoder_tb;
  localparam int DW = 64;
  localparam int KW = 8;
  localparam logic [31:0] PAT = 32'hDEADBEEF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;
  logic          m_tlast;
  logic          m_tvalid;
  logic          m_tready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] in_q[$];
  logic [DW-1:0] ed_q[$];
  logic [KW-1:0] ek_q[$];
  logic          el_q[$];

  always #10 clk = ~clk;

  stream_sideband_decoder #(.DATA_W(DW), .KEEP_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  function automatic logic [DW-1:0] mk_mark(input logic last, input logic [KW-1:0] keep);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1 -: 32] = PAT;
    w[KW:1] = keep;
    w[0] = last;
    return w;
  endfunction

  function automatic logic [KW-1:0] exp_keep(input logic last, input logic [KW-1:0] keep);
    return last ? keep : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [DW-1:0] d, input logic r);
    @(negedge clk);
    s_tvalid = v;
    s_tdata  = d;
    m_tready = r;
    #1;
  endtask

  task automatic beat_chk(input string tag, input logic [DW-1:0] d, input logic l, input logic [KW-1:0] k);
    chk(m_tvalid == 1'b1, {tag, " valid"}, DW'(m_tvalid), DW'(1));
    chk(m_tdata == d, {tag, " data"}, m_tdata, d);
    chk(m_tlast == l, {tag, " last"}, DW'(m_tlast), DW'(l));
    chk(m_tkeep == k, {tag, " keep"}, DW'(m_tkeep), DW'(k));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    put(1'b0, '0, 1'b1);
    chk(m_tvalid == 1'b0, "R8 reset valid", DW'(m_tvalid), DW'(0));
    chk(m_tlast == 1'b0, "R8 reset last", DW'(m_tlast), DW'(0));

    // R4: plain word while idle, stalled then accepted
    put(1'b1, 64'h1234567887654321, 1'b0);
    beat_chk("R4 plain", 64'h1234567887654321, 1'b0, '0);
    chk(s_tready == 1'b0, "R4 ready follows", DW'(s_tready), DW'(0));
    put(1'b1, 64'h1234567887654321, 1'b1);
    chk(s_tready == 1'b1, "R4 ready follows", DW'(s_tready), DW'(1));

    // R1: marker absorbed even with downstream stalled
    put(1'b1, 64'hDEADBEEF00000005, 1'b0);
    chk(s_tready == 1'b1, "R1 marker ready", DW'(s_tready), DW'(1));
    chk(m_tvalid == 1'b0, "R1 marker hidden", DW'(m_tvalid), DW'(0));
    // R7: gap cycles create no beat
    for (int i = 0; i < 4; i++) begin
      put(1'b0, {PAT, 32'h0}, 1'b1);
      chk(m_tvalid == 1'b0, "R7 gap no beat", DW'(m_tvalid), DW'(0));
    end
    // R2: worked example, stalled first
    put(1'b1, 64'h1234567887654321, 1'b0);
    beat_chk("R2 example", 64'h1234567887654321, 1'b1, 8'h02);
    chk(s_tready == 1'b0, "R7 ready follows", DW'(s_tready), DW'(0));
    put(1'b1, 64'h1234567887654321, 1'b1);
    beat_chk("R7 held fields", 64'h1234567887654321, 1'b1, 8'h02);
    put(1'b1, 64'hAAAA5555AAAA5555, 1'b1);
    beat_chk("R4 back idle", 64'hAAAA5555AAAA5555, 1'b0, '0);

    // R5 / R3: literal pattern word
    put(1'b1, 64'hDEADBEEF00000000, 1'b1);
    chk(m_tvalid == 1'b0, "R5 marker hidden", DW'(m_tvalid), DW'(0));
    put(1'b1, 64'hDEADBEEFFEEDCAFE, 1'b1);
    beat_chk("R5 R3 literal", 64'hDEADBEEFFEEDCAFE, 1'b0, '0);

    // R6: keep field without end flag is masked
    put(1'b1, 64'hDEADBEEF00000002, 1'b1);
    put(1'b1, 64'h5555AAAA5555AAAA, 1'b1);
    beat_chk("R6 masked", 64'h5555AAAA5555AAAA, 1'b0, '0);

    // R2: widest keep field
    put(1'b1, mk_mark(1'b1, 8'hFF), 1'b1);
    put(1'b1, 64'hDEADBEEF0BADF00D, 1'b1);
    beat_chk("R2 full keep", 64'hDEADBEEF0BADF00D, 1'b1, 8'hFF);

    // R8: reset while a payload is pending
    put(1'b1, 64'hDEADBEEF00000001, 1'b1);
    put(1'b0, '0, 1'b1);
    rst_n = 1'b0;
    #1;
    chk(m_tvalid == 1'b0, "R8 in reset", DW'(m_tvalid), DW'(0));
    @(negedge clk);
    rst_n = 1'b1;
    put(1'b1, 64'h0123456789ABCDEF, 1'b1);
    beat_chk("R8 after reset", 64'h0123456789ABCDEF, 1'b0, '0);
    put(1'b1, 64'hDEADBEEF00000000, 1'b1);
    chk(m_tvalid == 1'b0, "R8 marker after reset", DW'(m_tvalid), DW'(0));
    put(1'b1, 64'hDEADBEEF12345678, 1'b1);
    beat_chk("R8 literal after reset", 64'hDEADBEEF12345678, 1'b0, '0);
    put(1'b0, '0, 1'b1);

    // Random phase: R1 R2 R3 R4 R6 R7 with stalls on both sides
    for (int n = 0; n < 1500; n++) begin
      logic [DW-1:0] d;
      logic          l;
      logic [KW-1:0] k;
      bit            extra;
      d = {$urandom, $urandom};
      if ($urandom % 6 == 0) d[DW-1 -: 32] = PAT;
      l = ($urandom % 4 == 0);
      k = KW'($urandom);
      extra = ($urandom % 10 == 0);
      if (l || extra || d[DW-1 -: 32] == PAT) begin
        in_q.push_back(mk_mark(l, k));
        ed_q.push_back(d);
        el_q.push_back(l);
        ek_q.push_back(exp_keep(l, k));
      end else begin
        ed_q.push_back(d);
        el_q.push_back(1'b0);
        ek_q.push_back('0);
      end
      in_q.push_back(d);
    end

    begin
      int idx = 0;
      int cyc = 0;
      while ((idx < in_q.size() || ed_q.size() != 0) && cyc < 100000) begin
        logic v;
        cyc++;
        v = (idx < in_q.size()) && ($urandom % 4 != 0);
        put(v, v ? in_q[idx] : {$urandom, $urandom}, ($urandom % 3 != 0));
        if (m_tvalid && !s_tvalid)
          chk(1'b0, "R7 beat without input", DW'(m_tvalid), DW'(0));
        if (m_tvalid && m_tready) begin
          if (ed_q.size() == 0) begin
            chk(1'b0, "R1 extra beat", m_tdata, '0);
          end else begin
            chk(m_tdata == ed_q[0], "R3 random data", m_tdata, ed_q[0]);
            chk(m_tlast == el_q[0], "R2 random last", DW'(m_tlast), DW'(el_q[0]));
            chk(m_tkeep == ek_q[0], "R6 random keep", DW'(m_tkeep), DW'(ek_q[0]));
            void'(ed_q.pop_front());
            void'(el_q.pop_front());
            void'(ek_q.pop_front());
          end
        end
        if (s_tvalid && s_tready) idx++;
      end
      chk(ed_q.size() == 0, "R1 all beats out", DW'(ed_q.size()), DW'(0));
      chk(idx == in_q.size(), "R7 all words in", DW'(idx), DW'(in_q.size()));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule